// File: doc/BRIEF.md
# SDRAM Eight-Beat Burst Read Sequencer

This block reads eight contiguous 32-bit words from a synchronous DRAM built from two 16-bit devices with two banks each. A client raises a request with a byte address. In the idle state the block acknowledges at once and latches that address. It then opens the row, issues two back-to-back four-beat column reads, and waits out the automatic precharge before it takes the next request. The second read carries the auto-precharge flag, so the block never issues an explicit precharge.

The memory address pins are driven from the word address, not the byte address. Controller output n equals internal bit n+2, so the two byte-select bits never reach the DRAM and word 0 of a row sits at column 0. Each beat is captured from the data bus when it arrives. It is presented one cycle later on a strobe/data pair. CAS latency and the precharge wait are parameters.

Top module: `sdram_burst_rd`

## Requirements
- R1: `ack_o` is high exactly in a cycle where `req_i` is high, the sequencer is idle and reset is not active. `addr_i` is latched at the clock edge that ends that cycle.
- R2: The cycle after an acknowledge carries the activate command. The command code on `cmd_n_o` is {CS#,RAS#,CAS#,WE#} = 4'b0011. `dram_a_o[11:0]` equals latched address bits [21:10], and bit 21 selects the bank.
- R3: The cycle after activate carries a read, code 4'b0101. `dram_a_o` is {bank bit 21, 1'b0, 2'b00, address bits [9:2]}.
- R4: Exactly four cycles after the first read, a second read (code 4'b0101) is issued with `dram_a_o[10]` = 1 (auto-precharge). Its column field is (address bits [9:2] + 4) modulo 256.
- R5: In every other cycle, including idle, `cmd_n_o` is the no-operation code 4'b0111.
- R6: `beat_valid_o` is high for exactly eight consecutive cycles, from CL+1 to CL+8 cycles after the first read. In each of those cycles, `beat_data_o` is the `dq_i` value present in the preceding cycle.
- R7: No acknowledge and no activate occurs before the precharge wait has ended. A new request is first acknowledged CL+4+TPC_CYC cycles after the auto-precharge read.
- R8: Changes on `addr_i` after the acknowledge have no effect on the addresses of the running sequence.
- R9: While reset is asserted, `ack_o` and `beat_valid_o` are low and `cmd_n_o` is no-operation, whatever `req_i` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Read request |
| addr_i | input | 22 | Byte address of the first word |
| ack_o | output | 1 | Request accepted, address latched this edge |
| cmd_n_o | output | 4 | Active-low {CS#,RAS#,CAS#,WE#} |
| dram_a_o | output | 12 | Multiplexed row / column address to the DRAM |
| dq_i | input | 32 | Read data bus from the DRAM |
| beat_valid_o | output | 1 | Captured beat valid |
| beat_data_o | output | 32 | Captured beat |

## Verification
The bench builds the block with CL = 2 and TPC_CYC = 1. It sweeps sixteen addresses over both banks, many rows, and column bases that include 0, 252 (the second burst wraps to 0) and 255, with nonzero byte-select bits. A behavioural DRAM returns a word computed from bank, row and column, so every beat's expected value is arithmetic on the request address. Each next request is held up during the precharge cycle to expose the exact re-acknowledge point, and the address inputs are inverted throughout each sequence.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

  // Active-low {CS#, RAS#, CAS#, WE#}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_ACTV = 4'b0011,
    CMD_READ = 4'b0101
  } sdrd_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACT,
    S_RD,
    S_GAP,
    S_RDA,
    S_DRAIN,
    S_TPC
  } sdrd_state_e;

  // Burst length programmed into the devices; the command spacing depends on it.
  localparam int BURST_LEN = 4;

endpackage

// File: rtl/sdrd_rst_sync.sv
module sdrd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/sdrd_addr_mux.sv
module sdrd_addr_mux #(
  parameter int ADDR_W = 22,
  parameter int DA_W   = 12,
  parameter int COL_W  = 8
) (
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              row_phase,
  input  logic              second,
  input  logic              ap,
  output logic [DA_W-1:0]   dram_a
);

  localparam int PAD_W = DA_W - 2 - COL_W;
  localparam int BYTE_W = 2;

  logic [COL_W-1:0] col_base;
  logic [COL_W-1:0] col_step;
  logic [COL_W-1:0] col_word;
  logic             bank;

  assign col_base = addr_q[COL_W+BYTE_W-1:BYTE_W];
  assign col_step = second ? COL_W'(sdrd_pkg::BURST_LEN) : '0;
  assign col_word = col_base + col_step;
  assign bank     = addr_q[ADDR_W-1];

  always_comb begin
    if (row_phase) dram_a = addr_q[ADDR_W-1 -: DA_W];
    else           dram_a = {bank, ap, {PAD_W{1'b0}}, col_word};
  end

endmodule

// File: rtl/sdrd_seq.sv
module sdrd_seq
  import sdrd_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int CL      = 2,
  parameter int TPC_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ack_o,
  output logic [ADDR_W-1:0] addr_q_o,
  output sdrd_cmd_e         cmd_o,
  output logic              row_phase_o,
  output logic              second_o,
  output logic              ap_o,
  output logic              issue_o
);

  localparam int DRAIN_CYC = CL + BURST_LEN - 1;
  localparam int CNT_W     = $clog2(DRAIN_CYC + TPC_CYC + BURST_LEN + 1);

  sdrd_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_en;

  assign ack_o   = req_i & rst_n & (state_q == S_IDLE);
  assign addr_en = ack_o;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      S_IDLE:  if (req_i) state_d = S_ACT;
      S_ACT:   state_d = S_RD;
      S_RD: begin
        state_d = S_GAP;
        cnt_d   = CNT_W'(BURST_LEN - 2);
      end
      S_GAP: begin
        if (cnt_q == '0) state_d = S_RDA;
        else             cnt_d   = cnt_q - 1'b1;
      end
      S_RDA: begin
        state_d = S_DRAIN;
        cnt_d   = CNT_W'(DRAIN_CYC - 1);
      end
      S_DRAIN: begin
        if (cnt_q == '0) begin
          state_d = S_TPC;
          cnt_d   = CNT_W'(TPC_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      S_TPC: begin
        if (cnt_q == '0) state_d = S_IDLE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_i;
  end

  always_comb begin
    case (state_q)
      S_ACT:        cmd_o = CMD_ACTV;
      S_RD, S_RDA:  cmd_o = CMD_READ;
      default:      cmd_o = CMD_NOP;
    endcase
  end

  assign addr_q_o    = addr_q;
  assign row_phase_o = (state_q == S_ACT);
  assign second_o    = (state_q == S_RDA);
  assign ap_o        = (state_q == S_RDA);
  assign issue_o     = (state_q == S_RD) | (state_q == S_RDA);

  AST_ACTV_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (cmd_o == CMD_ACTV)); // R2

  AST_READ_AFTER_ACTV: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACTV) |=> (cmd_o == CMD_READ)); // R3

  // BURST_LEN is fixed at 4 in the package, so the depth is a constant.
  AST_READA_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RDA) |-> $past(cmd_o == CMD_READ, 4)); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(addr_q)); // R8

endmodule

// File: rtl/sdrd_beat_pipe.sv
module sdrd_beat_pipe #(
  parameter int CL   = 2,
  parameter int DQ_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [DQ_W-1:0] dq_i,
  output logic            beat_valid_o,
  output logic [DQ_W-1:0] beat_data_o
);

  localparam int BL   = sdrd_pkg::BURST_LEN;
  localparam int SH_W = CL + BL - 1;

  logic [SH_W-1:0] sh_q;
  logic            win;
  logic            vld_q;
  logic [DQ_W-1:0] data_q;

  // sh_q[i] is the issue pulse delayed by i+1 cycles.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SH_W-2:0], issue};
  end

  // Data is on the bus from CL to CL+BL-1 cycles after a read.
  always_comb begin
    win = 1'b0;
    for (int i = CL - 1; i < SH_W; i++) win = win | sh_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= win;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (win) data_q <= dq_i;
  end

  assign beat_valid_o = vld_q;
  assign beat_data_o  = data_q;

  AST_PIPE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sh_q) <= 2); // R6

endmodule

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd
  import sdrd_pkg::*;
#(
  parameter int ADDR_W  = 22,
  parameter int DA_W    = 12,
  parameter int COL_W   = 8,
  parameter int DQ_W    = 32,
  parameter int CL      = 2,
  parameter int TPC_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ack_o,
  output logic [3:0]        cmd_n_o,
  output logic [DA_W-1:0]   dram_a_o,
  input  logic [DQ_W-1:0]   dq_i,
  output logic              beat_valid_o,
  output logic [DQ_W-1:0]   beat_data_o
);

  logic              rst_s_n;
  logic [ADDR_W-1:0] addr_q;
  sdrd_cmd_e         cmd;
  logic              row_phase, second, ap, issue;

  sdrd_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  sdrd_seq #(
    .ADDR_W  (ADDR_W),
    .CL      (CL),
    .TPC_CYC (TPC_CYC)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .req_i       (req_i),
    .addr_i      (addr_i),
    .ack_o       (ack_o),
    .addr_q_o    (addr_q),
    .cmd_o       (cmd),
    .row_phase_o (row_phase),
    .second_o    (second),
    .ap_o        (ap),
    .issue_o     (issue)
  );

  sdrd_addr_mux #(
    .ADDR_W (ADDR_W),
    .DA_W   (DA_W),
    .COL_W  (COL_W)
  ) u_mux (
    .addr_q    (addr_q),
    .row_phase (row_phase),
    .second    (second),
    .ap        (ap),
    .dram_a    (dram_a_o)
  );

  sdrd_beat_pipe #(
    .CL   (CL),
    .DQ_W (DQ_W)
  ) u_pipe (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .issue        (issue),
    .dq_i         (dq_i),
    .beat_valid_o (beat_valid_o),
    .beat_data_o  (beat_data_o)
  );

  assign cmd_n_o = cmd;

  AST_FIRST_READ_NO_AP: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((cmd_n_o == CMD_READ) && ($past(cmd_n_o) == CMD_ACTV)) |-> !dram_a_o[10]); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    ack_o |-> !beat_valid_o); // R7

  AST_RESET_NOP: assert property (@(posedge clk)
    !rst_s_n |-> (cmd_n_o == CMD_NOP) && !ack_o); // R9

endmodule

// File: tb/sim_sdram_burst_rd.sv
module sim_sdram_burst_rd;

  localparam int CL      = 2;
  localparam int TPC_CYC = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [21:0] addr_i = '0;
  logic        ack_o;
  logic [3:0]  cmd_n_o;
  logic [11:0] dram_a_o;
  logic [31:0] dq_i = '0;
  logic        beat_valid_o;
  logic [31:0] beat_data_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  sdram_burst_rd #(.CL(CL), .TPC_CYC(TPC_CYC)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .addr_i       (addr_i),
    .ack_o        (ack_o),
    .cmd_n_o      (cmd_n_o),
    .dram_a_o     (dram_a_o),
    .dq_i         (dq_i),
    .beat_valid_o (beat_valid_o),
    .beat_data_o  (beat_data_o)
  );

  function automatic logic [31:0] pat(input logic bank, input logic [10:0] row,
                                      input logic [7:0] col);
    return {8'hC3, 4'h0, bank, row, col};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural DRAM, evaluated mid-cycle
  logic [31:0] rbuf [32];
  logic        open_bank = 1'b0;
  logic [10:0] open_row = '0;
  int          cyc = 0;
  int          last_ap = -100;

  initial for (int i = 0; i < 32; i++) rbuf[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_n_o == 4'b0011) begin
        // R7: activate only after the precharge wait
        chk(cyc > last_ap + CL + 3 + TPC_CYC, "R7 early activate", cyc, last_ap);
        open_bank = dram_a_o[11];
        open_row  = dram_a_o[10:0];
      end else if (cmd_n_o == 4'b0101) begin
        chk(dram_a_o[11] == open_bank, "R3 bank", dram_a_o[11], open_bank);
        for (int k = 0; k < 4; k++)
          rbuf[(cyc + CL + k) % 32] = pat(open_bank, open_row, dram_a_o[7:0] + 8'(k));
        if (dram_a_o[10]) last_ap = cyc;
      end
    end
    dq_i = rbuf[cyc % 32];
    rbuf[cyc % 32] = 32'hDEAD_0000 | 32'(cyc);
    cyc++;
  end

  task automatic run_read(input logic [21:0] a, input bit hold_next);
    logic [7:0] col0;
    logic [3:0] exp_cmd;
    col0   = a[9:2];
    req_i  = 1'b1;
    addr_i = a;
    #1;
    chk(ack_o == 1'b1, "R1 ack when idle", ack_o, 1);
    for (int k = 1; k <= CL + 10; k++) begin
      @(negedge clk);
      req_i  = (k == CL + 10) && hold_next;
      addr_i = ~a;   // R8: must not disturb the running sequence
      #1;
      if (k == 1)      exp_cmd = 4'b0011;
      else if (k == 2) exp_cmd = 4'b0101;
      else if (k == 6) exp_cmd = 4'b0101;
      else             exp_cmd = 4'b0111;
      chk(cmd_n_o == exp_cmd, "R5 command sequence", cmd_n_o, exp_cmd);
      if (k == 1)
        chk(dram_a_o == a[21:10], "R2 row address", dram_a_o, a[21:10]);
      if (k == 2)
        chk(dram_a_o == {a[21], 1'b0, 2'b00, col0}, "R3 first column", dram_a_o,
            {a[21], 1'b0, 2'b00, col0});
      if (k == 6)
        chk(dram_a_o == {a[21], 1'b1, 2'b00, 8'(col0 + 8'd4)}, "R4 second column",
            dram_a_o, {a[21], 1'b1, 2'b00, 8'(col0 + 8'd4)});
      if (k >= CL + 3 && k <= CL + 10) begin
        chk(beat_valid_o == 1'b1, "R6 beat valid", beat_valid_o, 1);
        chk(beat_data_o == pat(a[21], a[20:10], 8'(col0 + 8'(k - CL - 3))),
            "R6 beat data R8", beat_data_o,
            pat(a[21], a[20:10], 8'(col0 + 8'(k - CL - 3))));
      end else begin
        chk(beat_valid_o == 1'b0, "R6 no beat", beat_valid_o, 0);
      end
      if (k >= 1)
        chk(ack_o == 1'b0, "R7 no ack while busy", ack_o, 0);
    end
    #1;
    req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [21:0] a;
    logic [7:0]  c;
    req_i = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state with a request pending
    chk(ack_o == 1'b0, "R9 ack in reset", ack_o, 0);
    chk(cmd_n_o == 4'b0111, "R9 nop in reset", cmd_n_o, 4'b0111);
    chk(beat_valid_o == 1'b0, "R9 valid in reset", beat_valid_o, 0);
    req_i = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cmd_n_o == 4'b0111, "R5 idle nop", cmd_n_o, 4'b0111);
    chk(ack_o == 1'b0, "R1 no ack without request", ack_o, 0);
    for (int i = 0; i < 16; i++) begin
      if (i == 13)      c = 8'd252;
      else if (i == 14) c = 8'd255;
      else if (i == 15) c = 8'd0;
      else              c = 8'((i * 61 + 7) & 255);
      a = {i[0], 11'((i * 389 + 5) & 2047), c, 2'(i)};
      run_read(a, i != 15);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule